// File: doc/BRIEF.md
# Bidirectional Cascadable Column Shift-Latch Driver

This block is the logic core of a serial-in, parallel-out column driver for a display. A chain of shift stages takes one bit per rising edge of a serial shift clock. A direction input picks which way the bits travel. Two bidirectional serial pins swap roles with the direction. One pin takes data in and is left undriven by the block. The other carries the far-end stage out, so that several drivers can be chained.

A strobe-controlled hold register sits between the stages and the parallel outputs. It passes the stage contents while the strobe is high and freezes them while the strobe is low. An output gate comes after it. Blanking forces every output low. A power-control input held low forces every output high. With blanking low and power-control high, the outputs show the held pattern. A test input forces all outputs low and suspends shifting.

The shift clock, strobe and all other controls are sampled by the block's system clock, so the whole core runs in one clock domain.

Top module: `colshift_drv`

## Requirements
- R1: A synchronous reset clears every shift stage and the hold register to 0. After reset, with blanking low and power-control high, all outputs are 0 and the active serial output pin is 0.
- R2: With the direction input high, each shift-clock rise moves every stage one place toward the last stage and loads pin A into stage 1 (output bit 0). Pin B then carries the last stage (output bit N-1), so the first bit loaded reaches pin B after N rises.
- R3: With the direction input low, each shift-clock rise moves every stage one place toward stage 1 and loads pin B into the last stage (output bit N-1). Pin A then carries stage 1 (output bit 0), so the first bit loaded reaches pin A after N rises.
- R4: The serial output pin follows the direction input with no clock delay. Pin B shows the last stage while the direction is high, and pin A shows stage 1 while it is low. The input-role pin is released to high impedance.
- R5: Exactly one shift happens per low-to-high transition of the shift clock. While the shift clock stays high or stays low, the stages keep their contents.
- R6: While the strobe is high, the hold register takes the stage contents at every system clock edge, including the value that a shift on that same edge produces.
- R7: While the strobe is low, the hold register keeps its value, and the shift stages keep shifting.
- R8: Blanking high forces all outputs to 0, whatever the power-control input or the held data.
- R9: With blanking low and power-control low, all outputs are 1. With blanking low and power-control high, each output bit equals its held bit.
- R10: The test input high forces all outputs to 0 and blocks shifting. When it returns low, the stages, the hold register and the serial output are unchanged from before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples every control |
| rst | input | 1 | Synchronous reset, active high |
| shiftClk | input | 1 | Serial shift clock; its rising transition shifts |
| dirFwd | input | 1 | 1: pin A in, pin B out, toward last stage; 0: reverse |
| strobe | input | 1 | 1: hold register follows stages; 0: hold |
| blank | input | 1 | 1: all outputs low |
| powerCtl | input | 1 | 0 (with blank low): all outputs high |
| testMode | input | 1 | 1: outputs low, shifting suspended |
| pinA | inout | 1 | Serial data; input when dirFwd=1, output when dirFwd=0 |
| pinB | inout | 1 | Serial data; output when dirFwd=1, input when dirFwd=0 |
| outs | output | N (96) | Parallel column outputs, bit i is stage i+1 |

## Verification
A shift-clock rise that the system clock samples at an edge shifts the stages on that same edge. With the strobe high, the hold register takes the new value on that edge too, so the parallel outputs and the serial output pin are due one edge after the rise is driven. The gating inputs blank, powerCtl and testMode and the direction input act on the outputs and pins combinationally, with zero cycles of delay. The bench changes inputs on falling edges and reads results on the next falling edge, or a nanosecond after a purely combinational change. It keeps a reference model of the stages and the hold register, updated once per driven rise, and compares against that model.

// File: rtl/colshift_pkg.sv
package colshift_pkg;

  // strobes from control to datapath, one system clock cycle each
  typedef struct packed {
    logic doShift;    // advance the stages on this edge
    logic shiftFwd;   // 1: toward last stage, 0: toward stage 1
    logic loadLatch;  // hold register follows the stages
    logic outKill;    // force all outputs low
  } ctrlStrobe_t;

endpackage

// File: rtl/colshift_ctrl.sv
module colshift_ctrl
  import colshift_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        shiftClk,
  input  logic        dirFwd,
  input  logic        strobe,
  input  logic        testMode,
  output ctrlStrobe_t strobes
);

  logic shClkQ;

  // previous sample of the shift clock, used to detect its rise
  always_ff @(posedge clk) begin
    if (rst) shClkQ <= 1'b0;
    else     shClkQ <= shiftClk;
  end

  always_comb begin
    strobes.doShift   = shiftClk & ~shClkQ & ~testMode & ~rst;
    strobes.shiftFwd  = dirFwd;
    strobes.loadLatch = strobe;
    strobes.outKill   = testMode;
  end

endmodule

// File: rtl/colshift_dp.sv
module colshift_dp
  import colshift_pkg::*;
#(
  parameter int N = 96
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobes,
  input  logic        serInA,
  input  logic        serInB,
  input  logic        blank,
  input  logic        powerCtl,
  output logic        serOutFwd,
  output logic        serOutRev,
  output logic [N-1:0] outs
);

  localparam int LAST = N - 1;

  logic [N-1:0] stageQ, stageD;
  logic [N-1:0] latchQ, latchD;

  // next state of the shift stages
  always_comb begin
    stageD = stageQ;
    if (strobes.doShift) begin
      if (strobes.shiftFwd) stageD = {stageQ[LAST-1:0], serInA};
      else                  stageD = {serInB, stageQ[LAST:1]};
    end
  end

  // hold register is transparent to the new stage value when loading
  always_comb begin
    latchD = strobes.loadLatch ? stageD : latchQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageQ <= '0;
      latchQ <= '0;
    end else begin
      stageQ <= stageD;
      latchQ <= latchD;
    end
  end

  assign serOutFwd = stageQ[LAST];
  assign serOutRev = stageQ[0];

  // per-column gate: kill/blank low wins, then force high, then data
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign outs[i] = (strobes.outKill | blank) ? 1'b0 :
                     (~powerCtl)               ? 1'b1 : latchQ[i];
  end

endmodule

// File: rtl/colshift_drv.sv
module colshift_drv
  import colshift_pkg::*;
#(
  parameter int N = 96
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftClk,
  input  logic         dirFwd,
  input  logic         strobe,
  input  logic         blank,
  input  logic         powerCtl,
  input  logic         testMode,
  inout  wire          pinA,
  inout  wire          pinB,
  output logic [N-1:0] outs
);

  ctrlStrobe_t strobes;
  logic serOutFwd, serOutRev;

  colshift_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .shiftClk (shiftClk),
    .dirFwd   (dirFwd),
    .strobe   (strobe),
    .testMode (testMode),
    .strobes  (strobes)
  );

  colshift_dp #(.N(N)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .serInA    (pinA),
    .serInB    (pinB),
    .blank     (blank),
    .powerCtl  (powerCtl),
    .serOutFwd (serOutFwd),
    .serOutRev (serOutRev),
    .outs      (outs)
  );

  // input-role pin is released; output-role pin carries the far stage
  assign pinA = dirFwd ? 1'bz : serOutRev;
  assign pinB = dirFwd ? serOutFwd : 1'bz;

endmodule

// File: rtl/colshift_chk.sv
module colshift_chk #(
  parameter int N = 96
) (
  input logic         clk,
  input logic         rst,
  input logic         shiftClk,
  input logic         dirFwd,
  input logic         strobe,
  input logic         blank,
  input logic         powerCtl,
  input logic         testMode,
  input logic         pinB,
  input logic [N-1:0] outs
);

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !blank && powerCtl && !testMode) |-> (outs == '0));

  p_no_shift_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(shiftClk) && dirFwd && $past(dirFwd)) |-> $stable(pinB));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe) && $stable(blank) && $stable(powerCtl) && $stable(testMode))
      |-> $stable(outs));

  p_blank_low_r8: assert property (@(posedge clk) disable iff (rst)
    blank |-> (outs == '0));

  p_force_high_r9: assert property (@(posedge clk) disable iff (rst)
    (!blank && !powerCtl && !testMode) |-> (outs == '1));

  p_test_low_r10: assert property (@(posedge clk) disable iff (rst)
    testMode |-> (outs == '0));

endmodule

bind colshift_drv colshift_chk #(.N(N)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .shiftClk (shiftClk),
  .dirFwd   (dirFwd),
  .strobe   (strobe),
  .blank    (blank),
  .powerCtl (powerCtl),
  .testMode (testMode),
  .pinB     (pinB),
  .outs     (outs)
);

// File: tb/colshift_drv_tb_top.sv
`timescale 1ns/1ps
module colshift_drv_tb_top;

  localparam int N = 96;
  localparam time PERIOD = 20ns;

  logic clk = 1'b0;
  logic rst, shiftClk, dirFwd, strobe, blank, powerCtl, testMode;
  logic drvA, drvB, valA, valB;
  wire  pinA, pinB;
  logic [N-1:0] outs;

  logic [N-1:0] model, latchModel;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  assign pinA = drvA ? valA : 1'bz;
  assign pinB = drvB ? valB : 1'bz;

  colshift_drv #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .dirFwd(dirFwd),
    .strobe(strobe), .blank(blank), .powerCtl(powerCtl), .testMode(testMode),
    .pinA(pinA), .pinB(pinB), .outs(outs)
  );

  function automatic logic [N-1:0] expOuts();
    if (testMode || blank) return '0;
    if (!powerCtl)         return '1;
    return latchModel;
  endfunction

  task automatic chkVec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outs act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic setDir(bit fwd);
    dirFwd = fwd;
    drvA   = fwd;
    drvB   = !fwd;
  endtask

  // one shift-clock pulse; result due at the next falling edge
  task automatic shiftBit(bit b);
    valA = b; valB = b;
    shiftClk = 1'b1;
    @(negedge clk);
    shiftClk = 1'b0;
    if (!testMode) begin
      if (dirFwd) model = {model[N-2:0], b};
      else        model = {b, model[N-1:1]};
    end
    if (strobe) latchModel = model;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = '0; latchModel = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    chkVec("R1 reset outs", outs, '0);
    chkBit("R1 reset serial", pinB, 1'b0);
  endtask

  task automatic t_forward();
    setDir(1);
    shiftBit(1);
    chkVec("R2 first bit in stage 1", outs, {{(N-1){1'b0}}, 1'b1});
    chkVec("R6 latch follows on shift edge", outs, latchModel);
    for (int i = 1; i < N; i++) shiftBit(((i % 3) == 0) ^ ((i % 7) == 0));
    chkBit("R2 first bit at pin B after N", pinB, 1'b1);
    chkVec("R2 forward pattern", outs, model);
    shiftBit(0);
    chkBit("R2 cascade next bit", pinB, model[N-1]);
  endtask

  task automatic t_reverse();
    doReset();
    setDir(0);
    shiftBit(1);
    chkVec("R3 first bit in last stage", outs, {1'b1, {(N-1){1'b0}}});
    for (int i = 1; i < N; i++) shiftBit((i % 5) == 2);
    chkBit("R3 first bit at pin A after N", pinA, 1'b1);
    chkVec("R3 reverse pattern", outs, model);
  endtask

  task automatic t_dirSwap();
    setDir(1);
    #1;
    chkBit("R4 pin B shows last stage", pinB, model[N-1]);
    setDir(0);
    #1;
    chkBit("R4 pin A shows stage 1", pinA, model[0]);
    @(negedge clk);
  endtask

  task automatic t_steadyClock();
    setDir(1);
    valA = 1'b1;
    shiftClk = 1'b1;
    @(negedge clk);
    model = {model[N-2:0], 1'b1};
    latchModel = model;
    valA = 1'b0;
    repeat (4) @(negedge clk);
    chkVec("R5 one shift per rise (high)", outs, model);
    shiftClk = 1'b0;
    repeat (4) @(negedge clk);
    chkVec("R5 steady low no shift", outs, model);
  endtask

  task automatic t_latchHold();
    logic [N-1:0] held;
    held = latchModel;
    strobe = 1'b0;
    for (int i = 0; i < 4; i++) shiftBit(i[0]);
    chkVec("R7 outputs held", outs, held);
    chkBit("R7 stages still shift", pinB, model[N-1]);
    strobe = 1'b1;
    latchModel = model;
    @(negedge clk);
    chkVec("R6 latch transparent again", outs, model);
  endtask

  task automatic t_blank();
    blank = 1'b1;
    powerCtl = 1'b1;
    #1;
    chkVec("R8 blank with power high", outs, '0);
    powerCtl = 1'b0;
    #1;
    chkVec("R8 blank wins over force high", outs, '0);
    blank = 1'b0;
    powerCtl = 1'b1;
    #1;
    chkVec("R8 blank released", outs, expOuts());
    @(negedge clk);
  endtask

  task automatic t_forceHigh();
    powerCtl = 1'b0;
    #1;
    chkVec("R9 force high", outs, '1);
    powerCtl = 1'b1;
    #1;
    chkVec("R9 data shown", outs, latchModel);
    @(negedge clk);
  endtask

  task automatic t_testMode();
    logic [N-1:0] saved;
    logic savedPin;
    saved = model;
    savedPin = pinB;
    testMode = 1'b1;
    #1;
    chkVec("R10 test forces low", outs, '0);
    for (int i = 0; i < 5; i++) shiftBit(1);
    chkVec("R10 still low", outs, '0);
    testMode = 1'b0;
    @(negedge clk);
    chkVec("R10 stages unchanged", outs, saved);
    chkBit("R10 serial unchanged", pinB, savedPin);
  endtask

  task automatic t_resetAgain();
    doReset();
    chkVec("R1 reset clears loaded data", outs, '0);
    chkBit("R1 reset clears serial", pinB, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; shiftClk = 1'b0; strobe = 1'b1; blank = 1'b0;
    powerCtl = 1'b1; testMode = 1'b0; valA = 1'b0; valB = 1'b0;
    model = '0; latchModel = '0;
    setDir(1);
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_dirSwap();
    t_steadyClock();
    t_latchHold();
    t_blank();
    t_forceHigh();
    t_testMode();
    t_resetAgain();
    finish();
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

endmodule